// File: doc/BRIEF.md
# Memory Pattern Test Engine

This block tests a banked memory without help from software. Each pass has two phases. In the write phase the engine fills every word of the populated banks with an arithmetic sequence. It walks the address space with an odd stride and moves to the next bank whenever the word address carries out. In the read phase it visits the same locations in the same order and rebuilds each expected word. It compares that word with the data the memory returns.

A clean pass pulses a completion output, which can step an external counter. The engine then grows both the stride and the data increment, so that every pass uses a new address order and a new data pattern. Two events count as errors and restart the test with the pass parameters unchanged: a read mismatch and a parity indication.

On a mismatch the engine records four things: the failing location, the XOR difference, the bits that read back as 1 when 0 was expected, and the bits that read back as 0 when 1 was expected. It then reads the failing word a second time and keeps that value, which separates a hard fault from a transient one. The memory itself is outside the block and is reached through a request/acknowledge port.

Top module: `mem_pattern_engine`

## Requirements
- R1: While reset is asserted, `mem_req` and `pass_pulse` are low and `err_count` is zero. Reset loads the seed, stride and data increment from `cfg_seed`, `cfg_stride` and `cfg_incr`.
- R2: At the start of every pass, and on every restart, bit 0 of the working stride is set to 1, so the stride in use is always odd.
- R3: In the write phase the first word written is seed + increment. Each later write adds the increment once more, modulo 2^DW.
- R4: Both phases start at bank 0, word address 0. After each access the word address becomes address + stride modulo 2^AW. A carry out of that sum sets the bank to (bank + 1) AND `cfg_bank_mask`.
- R5: Each phase makes exactly (cfg_bank_mask + 1) x 2^AW accesses. A word counter of AW bits counts the accesses. Each time it overflows, an outer counter increments. The phase ends when the outer counter would exceed `cfg_bank_mask`.
- R6: The read phase repeats the write phase's locations, order and expected values. A read word that matches lets the engine go on without counting an error.
- R7: On a read mismatch `err_count` increases by one. The outputs then hold four values: `diag_diff` = read XOR expected, `diag_picked` = diff AND NOT expected, `diag_dropped` = diff AND expected, and the failing bank and word address.
- R8: After a mismatch the engine reads the failing location once more and holds that data on `diag_reread`. It then restarts from the write phase with the same seed, stride and increment.
- R9: When a read phase ends with no mismatch, `pass_pulse` is high for exactly one cycle and `err_count` does not change. The next seed becomes the last word of the pass, which is seed + N x increment for N accesses per phase. The stride grows by `cfg_stride_step` and the increment grows by `cfg_incr_step`.
- R10: A high `parity_err` while a request is outstanding, or while read data is awaited, in either phase, increases `err_count` by one. It restarts the test with the seed, stride and increment unchanged.
- R11: A request holds its bank, address, write flag and write data stable until `mem_ack` is high. Read data is taken only in a cycle where `mem_rvalid` is high, after the read has been acknowledged.
- R12: `err_count` stops at its maximum value, all ones, and does not wrap. Only reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_seed | input | DW | Seed loaded at reset |
| cfg_stride | input | AW | Address stride loaded at reset |
| cfg_incr | input | DW | Data increment loaded at reset |
| cfg_stride_step | input | AW | Added to the stride after a clean pass |
| cfg_incr_step | input | DW | Added to the data increment after a clean pass |
| cfg_bank_mask | input | BW | Populated banks minus one (a power of two minus one) |
| parity_err | input | 1 | Parity error reported by the memory |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_bank | output | BW | Bank number |
| mem_addr | output | AW | Word address within the bank |
| mem_wdata | output | DW | Write data |
| mem_ack | input | 1 | Request accepted |
| mem_rdata | input | DW | Read data |
| mem_rvalid | input | 1 | Read data valid |
| err_count | output | ECW | Saturating error count |
| pass_pulse | output | 1 | One-cycle pulse at the end of a clean pass |
| diag_diff | output | DW | XOR of read and expected data at the last mismatch |
| diag_picked | output | DW | Bits read as 1 where 0 was expected |
| diag_dropped | output | DW | Bits read as 0 where 1 was expected |
| diag_reread | output | DW | Data returned by the repeated read of the failing word |
| diag_bank | output | BW | Bank of the last mismatch |
| diag_addr | output | AW | Word address of the last mismatch |

## Verification
The properties make three assumptions about the inputs.
- `cfg_bank_mask` changes only while reset is asserted.
- `parity_err` is never high in a cycle where a request is acknowledged.
- `mem_rvalid` is raised only for a read that has already been acknowledged.

The bench keeps within these limits in the following ways.
- It changes the configuration only during reset and picks bank masks of the form 2^k - 1.
- It returns read data after a random delay and drives random junk on `mem_rdata` when `mem_rvalid` is low.
- It raises parity only in a cycle where the engine is requesting and the bench withholds the acknowledge.

// File: rtl/mem_pattern_engine.sv
module mem_pattern_engine #(
  parameter int DW  = 16,
  parameter int AW  = 16,
  parameter int BW  = 8,
  parameter int ECW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [DW-1:0]  cfg_seed,
  input  logic [AW-1:0]  cfg_stride,
  input  logic [DW-1:0]  cfg_incr,
  input  logic [AW-1:0]  cfg_stride_step,
  input  logic [DW-1:0]  cfg_incr_step,
  input  logic [BW-1:0]  cfg_bank_mask,
  input  logic           parity_err,
  output logic           mem_req,
  output logic           mem_we,
  output logic [BW-1:0]  mem_bank,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic           mem_ack,
  input  logic [DW-1:0]  mem_rdata,
  input  logic           mem_rvalid,
  output logic [ECW-1:0] err_count,
  output logic           pass_pulse,
  output logic [DW-1:0]  diag_diff,
  output logic [DW-1:0]  diag_picked,
  output logic [DW-1:0]  diag_dropped,
  output logic [DW-1:0]  diag_reread,
  output logic [BW-1:0]  diag_bank,
  output logic [AW-1:0]  diag_addr
);

  typedef enum logic [2:0] {
    ST_START, ST_REQ, ST_RWAIT, ST_RRREQ, ST_RRWAIT, ST_PASS
  } state_t;

  state_t        state;
  logic          rd_phase;
  logic [DW-1:0] seed, incr, expv;
  logic [AW-1:0] stride, addr, wcnt;
  logic [BW-1:0] bank;
  logic [BW:0]   outer;

  logic [AW:0]   addr_sum, wcnt_sum;
  logic [BW:0]   outer_nx;
  logic [BW-1:0] bank_nx;
  logic [DW-1:0] diff;
  logic          last_acc, abort, bump_err;

  assign addr_sum = {1'b0, addr} + {1'b0, stride};
  assign wcnt_sum = {1'b0, wcnt} + (AW+1)'(1);
  assign outer_nx = outer + (BW+1)'(wcnt_sum[AW]);
  assign last_acc = outer_nx > {1'b0, cfg_bank_mask};
  assign bank_nx  = addr_sum[AW] ? ((bank + BW'(1)) & cfg_bank_mask) : bank;
  assign diff     = mem_rdata ^ expv;
  assign abort    = parity_err && (state == ST_REQ || state == ST_RWAIT);
  assign bump_err = abort || (state == ST_RWAIT && mem_rvalid && diff != '0);

  assign mem_req    = state == ST_REQ || state == ST_RRREQ;
  assign mem_we     = state == ST_REQ && !rd_phase;
  assign mem_bank   = bank;
  assign mem_addr   = addr;
  assign mem_wdata  = expv;
  assign pass_pulse = state == ST_PASS;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_START;
      rd_phase     <= 1'b0;
      seed         <= cfg_seed;
      incr         <= cfg_incr;
      stride       <= cfg_stride;
      expv         <= '0;
      addr         <= '0;
      bank         <= '0;
      wcnt         <= '0;
      outer        <= '0;
      err_count    <= '0;
      diag_diff    <= '0;
      diag_picked  <= '0;
      diag_dropped <= '0;
      diag_reread  <= '0;
      diag_bank    <= '0;
      diag_addr    <= '0;
    end else begin
      if (bump_err && err_count != '1)
        err_count <= err_count + ECW'(1);

      unique case (state)
        ST_START: begin
          stride   <= stride | AW'(1);
          addr     <= '0;
          bank     <= '0;
          wcnt     <= '0;
          outer    <= '0;
          expv     <= seed + incr;
          rd_phase <= 1'b0;
          state    <= ST_REQ;
        end
        ST_REQ: begin
          if (abort) begin
            state <= ST_START;
          end else if (mem_ack) begin
            if (rd_phase) begin
              state <= ST_RWAIT;
            end else if (last_acc) begin
              rd_phase <= 1'b1;
              addr     <= '0;
              bank     <= '0;
              wcnt     <= '0;
              outer    <= '0;
              expv     <= seed + incr;
            end else begin
              addr  <= addr_sum[AW-1:0];
              bank  <= bank_nx;
              wcnt  <= wcnt_sum[AW-1:0];
              outer <= outer_nx;
              expv  <= expv + incr;
            end
          end
        end
        ST_RWAIT: begin
          if (abort) begin
            state <= ST_START;
          end else if (mem_rvalid) begin
            if (diff != '0) begin
              diag_diff    <= diff;
              diag_picked  <= diff & ~expv;
              diag_dropped <= diff & expv;
              diag_bank    <= bank;
              diag_addr    <= addr;
              state        <= ST_RRREQ;
            end else if (last_acc) begin
              state <= ST_PASS;
            end else begin
              addr  <= addr_sum[AW-1:0];
              bank  <= bank_nx;
              wcnt  <= wcnt_sum[AW-1:0];
              outer <= outer_nx;
              expv  <= expv + incr;
              state <= ST_REQ;
            end
          end
        end
        ST_RRREQ: begin
          if (mem_ack) state <= ST_RRWAIT;
        end
        ST_RRWAIT: begin
          if (mem_rvalid) begin
            diag_reread <= mem_rdata;
            state       <= ST_START;
          end
        end
        ST_PASS: begin
          seed   <= expv;
          stride <= stride + cfg_stride_step;
          incr   <= incr + cfg_incr_step;
          state  <= ST_START;
        end
        default: state <= ST_START;
      endcase
    end
  end

endmodule

// File: rtl/mem_pattern_engine_chk.sv
module mem_pattern_engine_chk #(
  parameter int DW  = 16,
  parameter int AW  = 16,
  parameter int BW  = 8,
  parameter int ECW = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           parity_err,
  input logic           mem_req,
  input logic           mem_ack,
  input logic           mem_we,
  input logic [BW-1:0]  mem_bank,
  input logic [AW-1:0]  mem_addr,
  input logic [DW-1:0]  mem_wdata,
  input logic [BW-1:0]  cfg_bank_mask,
  input logic [ECW-1:0] err_count,
  input logic           pass_pulse
);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack && !parity_err |=> mem_req && $stable(mem_bank) && $stable(mem_addr)
      && $stable(mem_we) && $stable(mem_wdata)); // R11

  AST_BANK_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_bank & ~cfg_bank_mask) == '0); // R4

  AST_ERR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (err_count == $past(err_count)) || (err_count == $past(err_count) + ECW'(1))); // R7

  AST_ERR_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    err_count == '1 |=> err_count == '1); // R12

  AST_PASS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pass_pulse |=> !pass_pulse && !mem_req); // R9

  AST_PASS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    pass_pulse |-> $stable(err_count)); // R9

endmodule

bind mem_pattern_engine mem_pattern_engine_chk #(.DW(DW), .AW(AW), .BW(BW), .ECW(ECW)) u_chk (
  .clk(clk), .rst_n(rst_n), .parity_err(parity_err), .mem_req(mem_req), .mem_ack(mem_ack),
  .mem_we(mem_we), .mem_bank(mem_bank), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .cfg_bank_mask(cfg_bank_mask), .err_count(err_count), .pass_pulse(pass_pulse)
);

// File: tb/mem_pattern_engine_bench.sv
module mem_pattern_engine_bench;
  localparam int DW = 16, AW = 4, BW = 3, ECW = 3;
  localparam int WORDS = 1 << (AW + BW);
  localparam int EMAX = (1 << ECW) - 1;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n;
  logic [DW-1:0] cfg_seed, cfg_incr, cfg_incr_step;
  logic [AW-1:0] cfg_stride, cfg_stride_step;
  logic [BW-1:0] cfg_bank_mask;
  logic parity_err, mem_req, mem_we, mem_ack, mem_rvalid, pass_pulse;
  logic [BW-1:0] mem_bank, diag_bank;
  logic [AW-1:0] mem_addr, diag_addr;
  logic [DW-1:0] mem_wdata, mem_rdata, diag_diff, diag_picked, diag_dropped, diag_reread;
  logic [ECW-1:0] err_count;

  mem_pattern_engine #(.DW(DW), .AW(AW), .BW(BW), .ECW(ECW)) u_mem_pattern_engine (
    .clk(clk), .rst_n(rst_n), .cfg_seed(cfg_seed), .cfg_stride(cfg_stride), .cfg_incr(cfg_incr),
    .cfg_stride_step(cfg_stride_step), .cfg_incr_step(cfg_incr_step), .cfg_bank_mask(cfg_bank_mask),
    .parity_err(parity_err), .mem_req(mem_req), .mem_we(mem_we), .mem_bank(mem_bank),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .mem_rvalid(mem_rvalid), .err_count(err_count), .pass_pulse(pass_pulse),
    .diag_diff(diag_diff), .diag_picked(diag_picked), .diag_dropped(diag_dropped),
    .diag_reread(diag_reread), .diag_bank(diag_bank), .diag_addr(diag_addr));

  int n_chk = 0, n_err = 0, cyc = 0;
  bit tmo = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) tmo = 1;
  end

  task automatic chk(bit ok, string rq, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  logic [DW-1:0] mem [WORDS];
  logic [DW-1:0] m_seed, m_inc, m_exp, e_diff, e_pick, e_drop, e_reread, f_hi, f_lo, rd_data, rd_val;
  logic [AW-1:0] m_stride, m_addr, e_addr;
  logic [BW-1:0] m_bank, e_bank;
  logic [AW+BW-1:0] f_idx;
  int m_k, m_phase, m_err, m_pass, seen_pass, rd_dly, diag_seen;
  bit f_on, par_req, chk_diag, chk_errc, rd_pend, req_cap, cap_we;
  logic [BW-1:0] cap_bank;
  logic [AW-1:0] cap_addr;
  logic [DW-1:0] cap_wd;

  function automatic int n_acc();
    return (int'(cfg_bank_mask) + 1) << AW;
  endfunction

  function automatic int sat_inc(int v);
    return (v < EMAX) ? v + 1 : v;
  endfunction

  task automatic m_restart();
    m_stride = m_stride | AW'(1);
    m_bank = '0; m_addr = '0; m_k = 0; m_phase = 0;
    m_exp = m_seed + m_inc;
  endtask

  task automatic m_advance();
    logic [AW:0] s;
    s = {1'b0, m_addr} + {1'b0, m_stride};
    m_addr = s[AW-1:0];
    if (s[AW]) m_bank = (m_bank + BW'(1)) & cfg_bank_mask;
    m_k++;
    m_exp = m_exp + m_inc;
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack = 0; mem_rvalid = 0; parity_err = 0; rd_pend = 0; req_cap = 0;
      mem_rdata = '0;
    end else begin
      parity_err = 0;
      mem_rvalid = 0;
      mem_rdata = DW'($urandom);
      if (pass_pulse) seen_pass++;
      if (mem_ack && req_cap) begin
        if (cap_we) begin
          if (chk_diag) begin
            chk(diag_diff == e_diff, "R7", "diff", diag_diff, e_diff);
            chk(diag_picked == e_pick, "R7", "picked", diag_picked, e_pick);
            chk(diag_dropped == e_drop, "R7", "dropped", diag_dropped, e_drop);
            chk({diag_bank, diag_addr} == {e_bank, e_addr}, "R7", "fail location",
                {diag_bank, diag_addr}, {e_bank, e_addr});
            chk(diag_reread == e_reread, "R8", "reread", diag_reread, e_reread);
            chk(int'(err_count) == m_err, "R7", "err after mismatch", err_count, m_err);
            chk_diag = 0;
            diag_seen++;
          end
          if (chk_errc) begin
            chk(int'(err_count) == m_err, "R10 R12", "err after parity", err_count, m_err);
            chk_errc = 0;
          end
          chk(m_phase == 0, "R5 R6", "write outside write phase", m_phase, 0);
          chk({cap_bank, cap_addr} == {m_bank, m_addr}, "R2 R4", "write location",
              {cap_bank, cap_addr}, {m_bank, m_addr});
          chk(cap_wd == m_exp, "R3", "write data", cap_wd, m_exp);
          mem[{cap_bank, cap_addr}] = cap_wd;
          if (m_k == n_acc() - 1) begin
            m_phase = 1; m_bank = '0; m_addr = '0; m_k = 0; m_exp = m_seed + m_inc;
          end else m_advance();
        end else begin
          chk(m_phase != 0, "R5 R6", "read inside write phase", m_phase, 1);
          chk({cap_bank, cap_addr} == {m_bank, m_addr}, (m_phase == 2) ? "R8" : "R4 R6",
              "read location", {cap_bank, cap_addr}, {m_bank, m_addr});
          rd_val = mem[{cap_bank, cap_addr}];
          if (f_on && {cap_bank, cap_addr} == f_idx) rd_val = (rd_val | f_hi) & ~f_lo;
          rd_data = rd_val;
          rd_pend = 1;
          rd_dly = $urandom % 3;
          if (m_phase == 2) begin
            m_restart();
            chk_diag = 1;
          end else if (rd_val != m_exp) begin
            m_err = sat_inc(m_err);
            e_diff = rd_val ^ m_exp;
            e_pick = e_diff & ~m_exp;
            e_drop = e_diff & m_exp;
            e_reread = rd_val;
            e_bank = m_bank; e_addr = m_addr;
            m_phase = 2;
          end else if (m_k == n_acc() - 1) begin
            m_pass++;
            m_seed = m_exp;
            m_stride = m_stride + cfg_stride_step;
            m_inc = m_inc + cfg_incr_step;
            m_restart();
          end else m_advance();
        end
      end else if (rd_pend) begin
        if (rd_dly == 0) begin
          mem_rvalid = 1; mem_rdata = rd_data; rd_pend = 0;
        end else rd_dly--;
      end
      mem_ack = mem_req && !rd_pend && ($urandom % 2 == 0);
      if (par_req && mem_req && !mem_ack && m_phase != 2) begin
        parity_err = 1; par_req = 0;
        m_err = sat_inc(m_err);
        m_restart();
        chk_errc = 1;
      end
      req_cap = mem_req; cap_we = mem_we; cap_bank = mem_bank; cap_addr = mem_addr; cap_wd = mem_wdata;
    end
  end

  task automatic do_reset(logic [DW-1:0] sd, logic [AW-1:0] st, logic [DW-1:0] inc,
                          logic [AW-1:0] sst, logic [DW-1:0] ist, logic [BW-1:0] msk);
    rst_n = 0;
    cfg_seed = sd; cfg_stride = st; cfg_incr = inc;
    cfg_stride_step = sst; cfg_incr_step = ist; cfg_bank_mask = msk;
    par_req = 0; f_on = 0; chk_diag = 0; chk_errc = 0;
    repeat (3) @(negedge clk);
    chk(!mem_req, "R1", "req in reset", mem_req, 0);
    chk(err_count == '0, "R1", "err in reset", err_count, 0);
    chk(!pass_pulse, "R1", "pass in reset", pass_pulse, 0);
    m_seed = sd; m_stride = st; m_inc = inc; m_err = 0; m_pass = 0; seen_pass = 0;
    m_restart();
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wait_passes(int n);
    int tgt;
    tgt = m_pass + n;
    while (m_pass < tgt && !tmo) @(negedge clk);
    repeat (8) @(negedge clk);
    chk(seen_pass == m_pass, "R9", "pass pulses", seen_pass, m_pass);
    chk(int'(err_count) == m_err, "R6 R11", "error count after passes", err_count, m_err);
  endtask

  task automatic inject_parity(int ph);
    while (!(m_phase == ph && m_k >= 2) && !tmo) @(negedge clk);
    par_req = 1;
    while (par_req && !tmo) @(negedge clk);
    while (chk_errc && !tmo) @(negedge clk);
  endtask

  initial begin
    int ds;
    void'($urandom(32'h1d2c));
    rst_n = 0;
    do_reset(DW'($urandom), AW'($urandom), DW'($urandom), AW'($urandom), DW'($urandom), 3'd0);
    wait_passes(3);

    do_reset(DW'($urandom), 4'd2, DW'($urandom), 4'd2, DW'($urandom), 3'd3);
    wait_passes(2);

    do_reset(DW'($urandom), AW'($urandom), DW'($urandom), AW'($urandom), DW'($urandom), 3'd7);
    wait_passes(1);
    f_idx = {BW'($urandom) & cfg_bank_mask, AW'($urandom)};
    f_hi = 16'h00f0; f_lo = 16'h0f00; f_on = 1;
    ds = diag_seen;
    while (diag_seen == ds && !tmo) @(negedge clk);
    f_on = 0;
    wait_passes(1);

    do_reset(DW'($urandom), AW'($urandom), DW'($urandom), AW'($urandom), DW'($urandom), 3'd1);
    f_idx = {BW'(0), AW'($urandom)};
    f_hi = 16'h0000; f_lo = 16'hffff; f_on = 1;
    ds = diag_seen;
    while (diag_seen == ds && !tmo) @(negedge clk);
    f_on = 0;
    inject_parity(0);
    inject_parity(1);
    wait_passes(1);
    for (int i = 0; i < 8; i++) inject_parity(i % 2);
    repeat (4) @(negedge clk);
    chk(int'(err_count) == EMAX, "R12", "saturated count", err_count, EMAX);
    wait_passes(1);
    chk(int'(err_count) == EMAX, "R12", "count held", err_count, EMAX);

    if (tmo) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule